// File: doc/BRIEF.md
# Multimode Six-Input Lookup Cell

This block holds 64 bits of state and, depending on a static two-bit mode input, uses them as a six-input combinational function (the same thing as a 64x1 read-only memory), a 64x1 single-port RAM with synchronous write, a 32x1 RAM with one read/write port and one read-only port, or a 32-stage serial shift register whose output stage is picked by an address. All reads are asynchronous: the data outputs follow the address inputs without a clock edge. The state changes only on a rising clock edge, and only through a write, a shift or a configuration load.

The contents come from the `INIT_VALUE` parameter on reset. At run time they can be replaced as a whole by pulsing `cfgLoad` with the new image on `cfgInit`. The mode is meant to be set once. Changing it only changes how the same 64 bits are addressed and updated. It never alters the stored bits by itself.

Top module: `lutcell_top`

## Requirements
- R1: While `rstN` is low at a rising edge, the 64 stored bits take `INIT_VALUE` (default 64'hF0E1_D2C3_B4A5_9687). Bit i is the bit that read address i returns.
- R2: When `cfgLoad` is high at a rising edge, all 64 bits take `cfgInit` in every mode. The load takes priority over any write or shift in that same cycle.
- R3: In mode 2'b00 (logic/ROM), `dataA` equals stored bit `addrA` (0..63) combinationally, with no clock edge in between.
- R4: In mode 2'b00, `wrEn` and `shEn` have no effect, so the contents stay unchanged.
- R5: In mode 2'b01 (single-port RAM), a rising edge with `wrEn` high writes `wrData` to bit `addrA`. `dataA` reads bit `addrA` and shows the old value until that edge.
- R6: In mode 2'b10 (dual-port), writes and `dataA` reads use bit `addrA[4:0]`, and `addrA[5]` is ignored. `dataB` reads bit `addrB` (0..31). Bits 32..63 are never written.
- R7: In mode 2'b11 (shift), a rising edge with `shEn` high moves `shIn` into bit 0 and bit i-1 into bit i for i = 1..31. Bits 32..63 are unchanged. `dataA` reads bit `addrA[4:0]`.
- R8: `tapLast` always equals stored bit 31, the last shift stage.
- R9: `dataB` is 0 in every mode other than 2'b10.
- R10: `shEn` has no effect in modes 2'b01 and 2'b10, and `wrEn` has no effect in mode 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates happen on its rising edge |
| rstN | input | 1 | Synchronous active-low reset; loads INIT_VALUE |
| cfgMode | input | 2 | Static mode select: 00 logic/ROM, 01 RAM, 10 dual-port, 11 shift |
| cfgLoad | input | 1 | Load the whole image from cfgInit at the next edge |
| cfgInit | input | 64 | Contents image for cfgLoad |
| addrA | input | 6 | Function inputs / port A address / shift tap select |
| addrB | input | 5 | Read-only port B address in dual-port mode |
| wrEn | input | 1 | Write enable for the RAM modes |
| wrData | input | 1 | Write data |
| shEn | input | 1 | Shift enable for shift mode |
| shIn | input | 1 | Serial input into stage 0 |
| dataA | output | 1 | Asynchronous read on port A |
| dataB | output | 1 | Asynchronous read on port B |
| tapLast | output | 1 | Stage 31 of the shift chain |

## Verification
Reads are combinational, so the bench changes an address and samples `dataA` or `dataB` one time step later, without waiting for a clock edge. Writes, shifts and loads take effect at exactly one rising edge. The bench drives those inputs on the falling edge, checks the old value just before the next rising edge, and checks the new value at the following falling edge. Whole-array comparisons switch to logic mode and sweep all 64 addresses. This shows at the ports that ignored enables changed nothing, and that the upper half survived the 32-bit modes.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;

  localparam int CELL_AW   = 6;
  localparam int CELL_BITS = 1 << CELL_AW;
  localparam int HALF_AW   = CELL_AW - 1;
  localparam int HALF_BITS = CELL_BITS / 2;

  typedef enum logic [1:0] {
    MODE_LOGIC = 2'b00,
    MODE_RAM   = 2'b01,
    MODE_DUAL  = 2'b10,
    MODE_SHIFT = 2'b11
  } cellMode_e;

  typedef struct packed {
    logic               load;
    logic               write;
    logic               shift;
    logic [CELL_AW-1:0] wrIdx;
    logic [CELL_AW-1:0] rdIdxA;
    logic [CELL_AW-1:0] rdIdxB;
    logic               portBOn;
  } cellStrobe_t;

endpackage

// File: rtl/lutcell_ctrl.sv
module lutcell_ctrl
  import lutcell_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cfgMode,
  input  logic               cfgLoad,
  input  logic               wrEn,
  input  logic               shEn,
  input  logic [CELL_AW-1:0] addrA,
  input  logic [HALF_AW-1:0] addrB,
  output cellStrobe_t        st
);

  cellMode_e mode;
  logic [CELL_AW-1:0] lowA;
  logic [CELL_AW-1:0] lowB;

  assign mode = cellMode_e'(cfgMode);
  assign lowA = {1'b0, addrA[HALF_AW-1:0]};
  assign lowB = {1'b0, addrB};

  always_comb begin
    st         = '0;
    st.load    = cfgLoad;
    st.rdIdxA  = addrA;
    case (mode)
      MODE_LOGIC: begin
        st.rdIdxA = addrA;
      end
      MODE_RAM: begin
        st.rdIdxA = addrA;
        st.wrIdx  = addrA;
        st.write  = wrEn & ~cfgLoad;
      end
      MODE_DUAL: begin
        st.rdIdxA  = lowA;
        st.wrIdx   = lowA;
        st.write   = wrEn & ~cfgLoad;
        st.rdIdxB  = lowB;
        st.portBOn = 1'b1;
      end
      MODE_SHIFT: begin
        st.rdIdxA = lowA;
        st.shift  = shEn & ~cfgLoad;
      end
      default: st.rdIdxA = addrA;
    endcase
  end

  AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.load, st.write, st.shift})); // R2

  AST_LOGIC_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'b00) |-> (!st.write && !st.shift)); // R4

  AST_NO_CROSS_EN: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgMode == 2'b11) |-> !st.write) and ((cfgMode != 2'b11) |-> !st.shift)); // R10

endmodule

// File: rtl/lutcell_store.sv
module lutcell_store
  import lutcell_pkg::*;
#(
  parameter logic [CELL_BITS-1:0] INIT_VALUE = 64'hF0E1_D2C3_B4A5_9687
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CELL_BITS-1:0] cfgInit,
  input  logic                 wrData,
  input  logic                 shIn,
  input  cellStrobe_t          st,
  output logic                 dataA,
  output logic                 dataB,
  output logic                 tapLast
);

  logic [CELL_BITS-1:0] bits;
  logic [CELL_BITS-1:0] nxt;

  for (genvar i = 0; i < CELL_BITS; i++) begin : g_bit
    logic hitWrite;
    assign hitWrite = st.write && (st.wrIdx == CELL_AW'(i));
    if (i < HALF_BITS) begin : g_chain
      logic srcBit;
      if (i == 0) begin : g_head
        assign srcBit = shIn;
      end else begin : g_body
        assign srcBit = bits[i-1];
      end
      assign nxt[i] = st.load  ? cfgInit[i] :
                      st.shift ? srcBit     :
                      hitWrite ? wrData     : bits[i];
    end else begin : g_upper
      assign nxt[i] = st.load  ? cfgInit[i] :
                      hitWrite ? wrData     : bits[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) bits <= INIT_VALUE;
    else       bits <= nxt;
  end

  assign dataA   = bits[st.rdIdxA];
  assign dataB   = st.portBOn ? bits[st.rdIdxB] : 1'b0;
  assign tapLast = bits[HALF_BITS-1];

  AST_LOAD_IMAGE: assert property (@(posedge clk) disable iff (!rstN)
    st.load |=> (bits == $past(cfgInit))); // R2

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    st.write |=> (bits[$past(st.wrIdx)] == $past(wrData))); // R5

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    st.shift |=> ((bits[0] == $past(shIn)) &&
                  (bits[HALF_BITS-1:1] == $past(bits[HALF_BITS-2:0])))); // R7

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!st.load && (st.shift || (st.write && !st.wrIdx[CELL_AW-1])))
      |=> $stable(bits[CELL_BITS-1:HALF_BITS])); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!st.load && !st.write && !st.shift) |=> $stable(bits)); // R4

endmodule

// File: rtl/lutcell_top.sv
module lutcell_top
  import lutcell_pkg::*;
#(
  parameter logic [CELL_BITS-1:0] INIT_VALUE = 64'hF0E1_D2C3_B4A5_9687
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           cfgMode,
  input  logic                 cfgLoad,
  input  logic [CELL_BITS-1:0] cfgInit,
  input  logic [CELL_AW-1:0]   addrA,
  input  logic [HALF_AW-1:0]   addrB,
  input  logic                 wrEn,
  input  logic                 wrData,
  input  logic                 shEn,
  input  logic                 shIn,
  output logic                 dataA,
  output logic                 dataB,
  output logic                 tapLast
);

  cellStrobe_t st;

  lutcell_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgMode (cfgMode),
    .cfgLoad (cfgLoad),
    .wrEn    (wrEn),
    .shEn    (shEn),
    .addrA   (addrA),
    .addrB   (addrB),
    .st      (st)
  );

  lutcell_store #(.INIT_VALUE(INIT_VALUE)) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .cfgInit (cfgInit),
    .wrData  (wrData),
    .shIn    (shIn),
    .st      (st),
    .dataA   (dataA),
    .dataB   (dataB),
    .tapLast (tapLast)
  );

  AST_PORTB_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode != 2'b10) |-> (dataB == 1'b0)); // R9

  AST_LOGIC_KEEPS_TAP: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'b00 && !cfgLoad) |=> $stable(tapLast)); // R4

endmodule

// File: tb/sim_lutcell_top.sv
`timescale 1ns/1ps
module sim_lutcell_top;

  localparam logic [63:0] RST_IMG = 64'hF0E1_D2C3_B4A5_9687;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgMode = 2'b00;
  logic        cfgLoad = 1'b0;
  logic [63:0] cfgInit = '0;
  logic [5:0]  addrA = '0;
  logic [4:0]  addrB = '0;
  logic        wrEn = 1'b0, wrData = 1'b0, shEn = 1'b0, shIn = 1'b0;
  logic        dataA, dataB, tapLast;

  int total = 0;
  int bad = 0;
  logic [63:0] model;
  bit finished = 0;

  always #5 clk = ~clk;

  lutcell_top u0 (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgLoad(cfgLoad),
    .cfgInit(cfgInit), .addrA(addrA), .addrB(addrB), .wrEn(wrEn),
    .wrData(wrData), .shEn(shEn), .shIn(shIn), .dataA(dataA),
    .dataB(dataB), .tapLast(tapLast)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cfgLoad = 0; wrEn = 0; shEn = 0;
  endtask

  // Sweep all 64 addresses in logic mode, compare against the model.
  task automatic checkArray(input string tag);
    logic [1:0] saved;
    logic [63:0] got;
    saved = cfgMode;
    idle();
    cfgMode = 2'b00;
    for (int a = 0; a < 64; a++) begin
      addrA = 6'(a);
      #1;
      got[a] = dataA;
    end
    chk(tag, got, model);
    @(negedge clk);
    cfgMode = saved;
  endtask

  task automatic tReset();
    rstN = 0;
    step(); step();
    rstN = 1;
    model = RST_IMG;
    checkArray("R1 reset image");
    #1 chk("R8 tapLast after reset", {63'd0, tapLast}, {63'd0, model[31]});
    chk("R9 dataB in logic mode", {63'd0, dataB}, 64'd0);
  endtask

  task automatic tLogic();
    cfgMode = 2'b00;
    cfgInit = 64'h0123_4567_89AB_CDEF;
    cfgLoad = 1;
    step();
    cfgLoad = 0;
    model = cfgInit;
    checkArray("R2 load image in logic mode");
    cfgMode = 2'b00;
    addrA = 6'd0;  #1 chk("R3 read addr 0",  {63'd0, dataA}, {63'd0, model[0]});
    addrA = 6'd63; #1 chk("R3 read addr 63", {63'd0, dataA}, {63'd0, model[63]});
    addrA = 6'd36; #1 chk("R3 read addr 36", {63'd0, dataA}, {63'd0, model[36]});
  endtask

  task automatic tLogicIgnore();
    cfgMode = 2'b00;
    for (int k = 0; k < 4; k++) begin
      addrA = 6'(k * 9); wrData = ~model[k * 9]; wrEn = 1; shEn = 1; shIn = ~model[0];
      step();
    end
    idle();
    checkArray("R4 enables ignored in logic mode");
  endtask

  task automatic tRam();
    cfgMode = 2'b01;
    for (int k = 0; k < 3; k++) begin
      logic [5:0] ad;
      ad = (k == 0) ? 6'd5 : (k == 1) ? 6'd63 : 6'd40;
      addrA = ad; wrData = ~model[ad]; wrEn = 1;
      #1 chk("R5 old value before edge", {63'd0, dataA}, {63'd0, model[ad]});
      step();
      model[ad] = wrData;
      wrEn = 0;
      #1 chk("R5 new value after edge", {63'd0, dataA}, {63'd0, model[ad]});
    end
    checkArray("R5 RAM contents");
  endtask

  task automatic tLoadPriority();
    cfgMode = 2'b01;
    cfgInit = 64'h5A5A_F00F_3C3C_0FF0;
    addrA = 6'd0; wrData = ~cfgInit[0]; wrEn = 1; cfgLoad = 1;
    step();
    idle();
    model = cfgInit;
    checkArray("R2 load beats write");
    cfgMode = 2'b11;
    shEn = 1; shIn = 1; cfgLoad = 1; cfgInit = 64'hFFFF_0000_1234_8765;
    step();
    idle();
    model = cfgInit;
    checkArray("R2 load beats shift");
  endtask

  task automatic tDual();
    cfgMode = 2'b10;
    addrA = 6'b100011; wrData = ~model[3]; wrEn = 1;
    step();
    model[3] = wrData;
    wrEn = 0;
    addrB = 5'd3;
    #1 chk("R6 port B sees port A write", {63'd0, dataB}, {63'd0, model[3]});
    addrA = 6'b100011;
    #1 chk("R6 addrA bit5 ignored on read", {63'd0, dataA}, {63'd0, model[3]});
    for (int b = 28; b < 32; b++) begin
      addrB = 5'(b);
      #1 chk("R6 port B read", {63'd0, dataB}, {63'd0, model[b]});
    end
    addrA = 6'd17; wrData = ~model[17]; wrEn = 1;
    step();
    model[17] = wrData;
    idle();
    checkArray("R6 dual-port contents, upper half kept");
  endtask

  task automatic tShift();
    logic [39:0] pat;
    pat = 40'hC3_A5F0_1E96;
    cfgMode = 2'b11;
    for (int k = 0; k < 40; k++) begin
      shIn = pat[k]; shEn = 1;
      step();
      model[31:0] = {model[30:0], pat[k]};
    end
    shEn = 0;
    #1 chk("R8 tapLast is stage 31", {63'd0, tapLast}, {63'd0, model[31]});
    addrA = 6'd0;  #1 chk("R7 tap 0",  {63'd0, dataA}, {63'd0, model[0]});
    addrA = 6'd13; #1 chk("R7 tap 13", {63'd0, dataA}, {63'd0, model[13]});
    addrA = 6'd45; #1 chk("R7 tap uses low 5 bits", {63'd0, dataA}, {63'd0, model[13]});
    chk("R9 dataB zero in shift mode", {63'd0, dataB}, 64'd0);
    checkArray("R7 shift contents, upper half kept");
  endtask

  task automatic tCrossIgnore();
    cfgMode = 2'b01; shEn = 1; shIn = ~model[0];
    step(); idle();
    checkArray("R10 shEn ignored in RAM mode");
    cfgMode = 2'b10; shEn = 1; shIn = ~model[0];
    step(); idle();
    checkArray("R10 shEn ignored in dual mode");
    cfgMode = 2'b11; wrEn = 1; addrA = 6'd2; wrData = ~model[2];
    step(); idle();
    checkArray("R10 wrEn ignored in shift mode");
  endtask

  task automatic tPortBQuiet();
    cfgInit = 64'hFFFF_FFFF_FFFF_FFFF;
    cfgLoad = 1;
    step(); idle();
    model = cfgInit;
    addrB = 5'd9;
    cfgMode = 2'b00; #1 chk("R9 dataB zero mode 00", {63'd0, dataB}, 64'd0);
    cfgMode = 2'b01; #1 chk("R9 dataB zero mode 01", {63'd0, dataB}, 64'd0);
    cfgMode = 2'b11; #1 chk("R9 dataB zero mode 11", {63'd0, dataB}, 64'd0);
    cfgMode = 2'b10; #1 chk("R6 dataB live in mode 10", {63'd0, dataB}, 64'd1);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tLogic();
    tLogicIgnore();
    tRam();
    tLoadPriority();
    tDual();
    tShift();
    tCrossIgnore();
    tPortBQuiet();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule